// File: doc/BRIEF.md
# Register File with Constant Generator

This block holds the sixteen architectural registers of a small 16-bit processor core and serves them through one source read port, one destination read port and one write port. Register 0 is the program counter, register 1 the stack pointer, register 2 the status register, and registers 4 to 15 are general-purpose storage for data or addresses.

The source read port takes a 2-bit addressing-mode field. When that port selects register 2 or register 3, the mode can replace the stored value with a hardwired constant. Instructions can then use common small values without an extra immediate word. Register 3 holds no state and acts only as a constant source.

The block also moves the stack pointer by one word for push and pop. The program counter and the stack pointer always keep bit 0 at zero. Reads are combinational. Writes and stack steps take effect on the next rising clock edge.

Top module: `reg_file_cg`

## Requirements
- R1: An active-low reset clears every register. After reset, `pc_o`, `sp_o` and every read of registers 0, 1, 2 and 4 to 15 return 0000h.
- R2: A write to any of registers 4 to 15 appears on both read ports after the next rising edge. A read of the register being written in that same cycle returns the old value.
- R3: A write to register 0 stores the data with bit 0 forced to zero.
- R4: A write to register 1 stores the data with bit 0 forced to zero.
- R5: A source read of register 3 returns 0000h, 0001h, 0002h and FFFFh for mode values 0, 1, 2 and 3.
- R6: A source read of register 2 returns the stored status value for mode 0, 0000h for mode 1, 0004h for mode 2 and 0008h for mode 3. The destination port always returns the stored status value.
- R7: Writes to register 3 have no effect. A mode-0 source read of register 3 and any destination read of register 3 return 0000h.
- R8: `sp_push_i` alone lowers the stack pointer by 2, and `sp_pop_i` alone raises it by 2, both modulo 2^16. When both are asserted, the stack pointer keeps its value.
- R9: An explicit write to register 1 in the same cycle as a push or pop takes priority, and the step is dropped.
- R10: The mode field has no effect on source reads of registers 0, 1 and 4 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_addr_i | input | 4 | Source read register index |
| src_mode_i | input | 2 | Addressing-mode field for constant substitution |
| src_data_o | output | 16 | Source read data or generated constant |
| dst_addr_i | input | 4 | Destination read register index |
| dst_data_o | output | 16 | Destination read data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Write register index |
| wr_data_i | input | 16 | Write data |
| sp_push_i | input | 1 | Lower stack pointer by one word |
| sp_pop_i | input | 1 | Raise stack pointer by one word |
| pc_o | output | 16 | Current program counter |
| sp_o | output | 16 | Current stack pointer |

## Verification
The bench builds the block with its default parameters: 16-bit data and sixteen registers. With these values every index is reachable, including both constant sources and the full set of twelve general-purpose registers. The 16-bit width also brings the stack-pointer wrap within reach: a push from 0000h gives FFFEh, and a pop from FFFEh gives 0000h. The directed tasks also cover the write-versus-step collision, a read of a register during its own write cycle, and every mode value on each constant source.

// File: rtl/reg_file_pkg.sv
package reg_file_pkg;
  localparam int unsigned PC_IDX = 0;
  localparam int unsigned SP_IDX = 1;
  localparam int unsigned SR_IDX = 2;
  localparam int unsigned CG_IDX = 3;

  typedef enum logic [1:0] {
    AM_REG  = 2'd0,
    AM_IDX  = 2'd1,
    AM_IND  = 2'd2,
    AM_INCR = 2'd3
  } addr_mode_e;
endpackage

// File: rtl/rf_const_gen.sv
module rf_const_gen
  import reg_file_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  addr_mode_e        mode_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = raw_i;
    if (addr_i == ADDR_W'(CG_IDX)) begin
      unique case (mode_i)
        AM_REG:  data_o = '0;
        AM_IDX:  data_o = DATA_W'(1);
        AM_IND:  data_o = DATA_W'(2);
        AM_INCR: data_o = '1;
        default: data_o = '0;
      endcase
    end else if (addr_i == ADDR_W'(SR_IDX)) begin
      unique case (mode_i)
        AM_REG:  data_o = raw_i;
        AM_IDX:  data_o = '0;
        AM_IND:  data_o = DATA_W'(4);
        AM_INCR: data_o = DATA_W'(8);
        default: data_o = raw_i;
      endcase
    end
  end
endmodule

// File: rtl/rf_sp_step.sv
module rf_sp_step #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] sp_q_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              wr_sp_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              sp_we_o,
  output logic [DATA_W-1:0] sp_d_o
);
  localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(2);

  always_comb begin
    sp_we_o = wr_sp_i || (push_i ^ pop_i);
    if (wr_sp_i)     sp_d_o = wr_data_i;
    else if (push_i) sp_d_o = sp_q_i - WORD_STEP;
    else             sp_d_o = sp_q_i + WORD_STEP;
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import reg_file_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic                             sp_we_i,
  input  logic [DATA_W-1:0]                sp_d_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  localparam logic [DATA_W-1:0] EVEN_MASK = {{(DATA_W-1){1'b1}}, 1'b0};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == CG_IDX) begin : g_const
      assign regs_o[i] = '0;
    end else if (i == SP_IDX) begin : g_sp
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (sp_we_i) q <= sp_d_i & EVEN_MASK;
      end
      assign regs_o[i] = q;
    end else begin : g_plain
      localparam logic [DATA_W-1:0] MASK = (i == PC_IDX) ? EVEN_MASK : '1;
      logic [DATA_W-1:0] q;
      logic              we;
      assign we = wr_en_i && (wr_addr_i == ADDR_W'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we) q <= wr_data_i & MASK;
      end
      assign regs_o[i] = q;
    end
  end
endmodule

// File: rtl/reg_file_cg.sv
module reg_file_cg
  import reg_file_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [1:0]        src_mode_i,
  output logic [DATA_W-1:0] src_data_o,
  input  logic [ADDR_W-1:0] dst_addr_i,
  output logic [DATA_W-1:0] dst_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sp_push_i,
  input  logic              sp_pop_i,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] sp_o
);
  localparam logic [DATA_W-1:0] EVEN_MASK = {{(DATA_W-1){1'b1}}, 1'b0};

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic                            wr_sp, sp_we;
  logic [DATA_W-1:0]               sp_d;

  assign wr_sp = wr_en_i && (wr_addr_i == ADDR_W'(SP_IDX));

  rf_sp_step #(.DATA_W(DATA_W)) u_sp_step (
    .sp_q_i    (regs[SP_IDX]),
    .push_i    (sp_push_i),
    .pop_i     (sp_pop_i),
    .wr_sp_i   (wr_sp),
    .wr_data_i (wr_data_i),
    .sp_we_o   (sp_we),
    .sp_d_o    (sp_d)
  );

  rf_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sp_we_i   (sp_we),
    .sp_d_i    (sp_d),
    .regs_o    (regs)
  );

  rf_const_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cg (
    .addr_i (src_addr_i),
    .mode_i (addr_mode_e'(src_mode_i)),
    .raw_i  (regs[src_addr_i]),
    .data_o (src_data_o)
  );

  assign dst_data_o = regs[dst_addr_i];
  assign pc_o       = regs[PC_IDX];
  assign sp_o       = regs[SP_IDX];

  assert_pc_even_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(PC_IDX)) |=> pc_o == ($past(wr_data_i) & EVEN_MASK));

  assert_sp_write_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sp |=> sp_o == ($past(wr_data_i) & EVEN_MASK));

  assert_sp_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_push_i && !sp_pop_i && !wr_sp) |=> sp_o == $past(sp_o) - DATA_W'(2));

  assert_sp_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_pop_i && !sp_push_i && !wr_sp) |=> sp_o == $past(sp_o) + DATA_W'(2));

  assert_sp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_pop_i && sp_push_i && !wr_sp) |=> $stable(sp_o));

  assert_r3_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_addr_i == ADDR_W'(CG_IDX) && src_mode_i == AM_REG) |-> src_data_o == '0);

  assert_sr_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_addr_i == ADDR_W'(SR_IDX) && src_mode_i == AM_REG && dst_addr_i == ADDR_W'(SR_IDX))
      |-> src_data_o == dst_data_o);
endmodule

// File: tb/reg_file_cg_tb_top.sv
module reg_file_cg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_addr = '0, dst_addr = '0, wr_addr = '0;
  logic [1:0]  src_mode = '0;
  logic [15:0] src_data, dst_data, wr_data = '0, pc, sp;
  logic        wr_en = 1'b0, push = 1'b0, pop = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reg_file_cg dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .src_addr_i(src_addr), .src_mode_i(src_mode), .src_data_o(src_data),
    .dst_addr_i(dst_addr), .dst_data_o(dst_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sp_push_i(push), .sp_pop_i(pop), .pc_o(pc), .sp_o(sp)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, clock once, settle after the edge
  task automatic cycle();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic rd_src(input logic [3:0] a, input logic [1:0] m);
    @(negedge clk); src_addr = a; src_mode = m; #1;
  endtask

  task automatic t_reset();
    chk("R1 pc", pc, 16'h0000);
    chk("R1 sp", sp, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      if (i == 3) continue;
      rd_src(i[3:0], 2'd0); dst_addr = i[3:0]; #1;
      chk("R1 src", src_data, 16'h0000);
      chk("R1 dst", dst_data, 16'h0000);
    end
  endtask

  task automatic t_general();
    for (int i = 4; i < 16; i++) wr(i[3:0], 16'hA000 + 16'(i * 16'h0111));
    for (int i = 4; i < 16; i++) begin
      rd_src(i[3:0], 2'd0); dst_addr = i[3:0]; #1;
      chk("R2 src", src_data, 16'hA000 + 16'(i * 16'h0111));
      chk("R2 dst", dst_data, 16'hA000 + 16'(i * 16'h0111));
    end
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd7; wr_data = 16'h5A5A; src_addr = 4'd7; src_mode = 2'd0; dst_addr = 4'd7; #1;
    chk("R2 same-cycle src old", src_data, 16'hA000 + 16'(7 * 16'h0111));
    chk("R2 same-cycle dst old", dst_data, 16'hA000 + 16'(7 * 16'h0111));
    cycle(); wr_en = 1'b0;
    chk("R2 after edge", src_data, 16'h5A5A);
  endtask

  task automatic t_pc();
    wr(4'd0, 16'h1235);
    chk("R3 pc_o", pc, 16'h1234);
    rd_src(4'd0, 2'd0);
    chk("R3 src", src_data, 16'h1234);
    wr(4'd0, 16'hFFFF);
    chk("R3 pc_o all ones", pc, 16'hFFFE);
  endtask

  task automatic t_sp_write();
    wr(4'd1, 16'h0FFF);
    chk("R4 sp_o", sp, 16'h0FFE);
    @(negedge clk); dst_addr = 4'd1; #1;
    chk("R4 dst", dst_data, 16'h0FFE);
  endtask

  task automatic step(input logic pu, input logic po);
    @(negedge clk); push = pu; pop = po;
    cycle();
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic t_push_pop();
    wr(4'd1, 16'h0400);
    step(1'b1, 1'b0); chk("R8 push", sp, 16'h03FE);
    step(1'b1, 1'b0); chk("R8 push twice", sp, 16'h03FC);
    step(1'b0, 1'b1); chk("R8 pop", sp, 16'h03FE);
    step(1'b1, 1'b1); chk("R8 push+pop hold", sp, 16'h03FE);
    wr(4'd1, 16'h0000);
    step(1'b1, 1'b0); chk("R8 push wrap", sp, 16'hFFFE);
    step(1'b0, 1'b1); chk("R8 pop wrap", sp, 16'h0000);
  endtask

  task automatic t_sp_prio();
    wr(4'd1, 16'h0800);
    @(negedge clk); push = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 16'h0200;
    cycle(); push = 1'b0; wr_en = 1'b0;
    chk("R9 write beats push", sp, 16'h0200);
    @(negedge clk); pop = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 16'h0301;
    cycle(); pop = 1'b0; wr_en = 1'b0;
    chk("R9 write beats pop", sp, 16'h0300);
  endtask

  task automatic t_cg3();
    logic [15:0] exp [4] = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFF};
    for (int m = 0; m < 4; m++) begin
      rd_src(4'd3, m[1:0]);
      chk("R5 r3 const", src_data, exp[m]);
    end
  endtask

  task automatic t_cg2();
    logic [15:0] exp [4] = '{16'h0107, 16'h0000, 16'h0004, 16'h0008};
    wr(4'd2, 16'h0107);
    for (int m = 0; m < 4; m++) begin
      rd_src(4'd2, m[1:0]); dst_addr = 4'd2; #1;
      chk("R6 r2 src", src_data, exp[m]);
      chk("R6 r2 dst", dst_data, 16'h0107);
    end
  endtask

  task automatic t_r3_write();
    wr(4'd3, 16'hABCD);
    rd_src(4'd3, 2'd0); dst_addr = 4'd3; #1;
    chk("R7 src mode0", src_data, 16'h0000);
    chk("R7 dst", dst_data, 16'h0000);
    rd_src(4'd3, 2'd3);
    chk("R7 mode3 still const", src_data, 16'hFFFF);
  endtask

  task automatic t_mode_ignored();
    wr(4'd9, 16'h3C3C);
    wr(4'd0, 16'h8888);
    for (int m = 0; m < 4; m++) begin
      rd_src(4'd9, m[1:0]);
      chk("R10 r9", src_data, 16'h3C3C);
      rd_src(4'd0, m[1:0]);
      chk("R10 r0", src_data, 16'h8888);
      rd_src(4'd1, m[1:0]);
      chk("R10 r1", src_data, sp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_general();
    t_pc();
    t_sp_write();
    t_push_pop();
    t_sp_prio();
    t_cg3();
    t_cg2();
    t_r3_write();
    t_mode_ignored();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule